// File: doc/BRIEF.md
# Memory Error Logging Controller

This block sits beside a protected RAM and converts the error strobes of its checker into status and notifications for one processor subsystem. Each cycle the checker may present one read report: the requesting master (CPU, DMA engine or co-processor), the access address, a single-bit flag, a double-bit flag, an address-fault flag, whether the RAM is parity- or ECC-protected, and whether the access came from the debugger. The block sorts the report into correctable, uncorrectable and address-fault classes. It counts correctable events against a programmable threshold and pulses an interrupt when the threshold is reached. It pulses a non-maskable interrupt (NMI) for every uncorrectable or address-fault event.

For each class and each master the block holds a sticky flag and the first faulting address. Software reads and clears these through a small word-addressed register port. Writes take effect at the clock edge and reads are combinational. Threshold detection runs in a two-state machine. ST_ARMED moves to ST_SPENT on the increment that makes the count equal the threshold. ST_SPENT moves back to ST_ARMED when the count is cleared or the threshold is rewritten. The interrupt pulses only on the ST_ARMED to ST_SPENT transition, and only while the enable bit is set.

Register map (word addresses):
- 0: control. Bit 0 enables the interrupt. Writing 1 to bit 1 clears the count.
- 1: threshold.
- 2: count, read-only.
- 3: flags. Reads return the flags; writing 1 to a bit clears that flag.
- 4 + 3·class + master: latched address. Class is 0 correctable, 1 uncorrectable, 2 address fault.

Top module: `mem_err_log`

## Requirements
- R1: A report is correctable when ev_sbe is set, ev_parity_ram is clear and ev_debug is clear. Each correctable report adds exactly one to the count (register 2). The count holds at 2^CW-1 instead of wrapping.
- R2: corr_irq is high for exactly one cycle, on the cycle after the increment that makes the count equal the threshold (register 1), and only if control bit 0 is set. A threshold of 0 never raises corr_irq. Increments past the threshold never raise it again.
- R3: A report is uncorrectable when ev_dbe is set, or when ev_sbe and ev_parity_ram are both set, and ev_debug is clear. It raises nmi for one cycle, on the cycle after the report. It also sets the uncorrectable flag of that master.
- R4: A report with ev_addr_err set raises nmi for one cycle after the report and sets the address-fault flag of that master. ev_debug does not mask it.
- R5: While ev_debug is set, correctable and uncorrectable content is ignored. No count, flag, address, corr_irq or nmi changes.
- R6: Master codes are 0 CPU, 1 DMA and 2 co-processor. Flag bit 3·class+master belongs to that master and class, and the address sits at register 4+3·class+master. Co-processor faults also drive nmi. Master code 3 is ignored.
- R7: Flags are sticky. While a flag is set, its address register keeps the first captured address. Writing 1 to a flag bit in register 3 clears that flag; writing 0 leaves it unchanged.
- R8: Writing 1 to control bit 1 sets the count to zero. This write wins over a same-cycle increment and re-arms threshold detection.
- R9: A report with both ev_sbe and ev_dbe set on an ECC RAM is logged as correctable and as uncorrectable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ev_valid | input | 1 | a read report is present this cycle |
| ev_master | input | 2 | requesting master code |
| ev_addr | input | AW | access address |
| ev_sbe | input | 1 | single-bit error seen |
| ev_dbe | input | 1 | double-bit error seen |
| ev_addr_err | input | 1 | address fault seen |
| ev_parity_ram | input | 1 | RAM is parity-protected (else ECC) |
| ev_debug | input | 1 | access came from the debugger |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | RAW | register word address |
| reg_wdata | input | RDW | register write data |
| reg_rdata | output | RDW | register read data (combinational) |
| corr_irq | output | 1 | correctable-threshold interrupt pulse |
| nmi | output | 1 | non-maskable interrupt pulse |

## Verification
Every result of a report is registered once. The count, the flags, the addresses, corr_irq and nmi all become visible on the cycle after the edge that sampled the report. corr_irq and nmi must be low again one cycle later. The bench drives each report on a falling edge and samples at the next falling edge. At that point the result is due and the pulse is still high. It then advances one more cycle to confirm the pulse has dropped. Register writes follow the same single-edge rule, and reads are combinational, so the bench settles the read address before sampling it.

// File: rtl/mel_pkg.sv
package mel_pkg;
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_SPENT = 1'b1
    } thr_state_t;

    localparam int NCLASS     = 3;
    localparam int CLS_CORR   = 0;
    localparam int CLS_UNC    = 1;
    localparam int CLS_AFAULT = 2;

    localparam int REG_CTRL  = 0;
    localparam int REG_THR   = 1;
    localparam int REG_COUNT = 2;
    localparam int REG_FLAGS = 3;
    localparam int REG_ADDR0 = 4;
endpackage

// File: rtl/mel_classify.sv
module mel_classify #(
    parameter int NM = 3,
    parameter int MW = 2
) (
    input  logic          ev_valid,
    input  logic [MW-1:0] ev_master,
    input  logic          ev_sbe,
    input  logic          ev_dbe,
    input  logic          ev_addr_err,
    input  logic          ev_parity_ram,
    input  logic          ev_debug,
    output logic [NM-1:0] corr_hit,
    output logic [NM-1:0] unc_hit,
    output logic [NM-1:0] afault_hit
);
    logic live;
    logic is_corr;
    logic is_unc;

    always_comb begin
        live    = ev_valid && (int'(ev_master) < NM);
        is_corr = live && !ev_debug && ev_sbe && !ev_parity_ram;
        is_unc  = live && !ev_debug && (ev_dbe || (ev_sbe && ev_parity_ram));
    end

    for (genvar m = 0; m < NM; m++) begin : g_sel
        always_comb begin
            corr_hit[m]   = is_corr && (int'(ev_master) == m);
            unc_hit[m]    = is_unc && (int'(ev_master) == m);
            afault_hit[m] = live && ev_addr_err && (int'(ev_master) == m);
        end
    end

    always_comb begin
        assert_onehot_master_R6 : assert ($onehot0(corr_hit | unc_hit | afault_hit));
    end
endmodule

// File: rtl/mel_corr_counter.sv
module mel_corr_counter
    import mel_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    input  logic          thr_wr,
    input  logic [CW-1:0] thr,
    input  logic          irq_en,
    output logic [CW-1:0] count,
    output logic          irq
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    thr_state_t state, state_nx;
    logic       hit;
    logic [CW-1:0] count_nx;

    always_comb begin
        hit = inc && !clr && (count != CMAX) && (thr != '0)
              && ((count + 1'b1) == thr);
    end

    always_comb begin
        count_nx = count;
        if (clr)
            count_nx = '0;
        else if (inc && count != CMAX)
            count_nx = count + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: if (hit) state_nx = ST_SPENT;
            ST_SPENT: if (clr || thr_wr) state_nx = ST_ARMED;
            default:  state_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (state == ST_ARMED) && hit && irq_en;
    end

    assert_count_step_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != CMAX) |=> (count == $past(count) + 1'b1));
    assert_count_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !clr) |=> (count == CMAX));
    assert_irq_pulse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_enabled_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(irq_en) && count == $past(thr) && count != '0));
    assert_clear_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !irq));
endmodule

// File: rtl/mel_log_slot.sv
module mel_log_slot #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic          clr,
    input  logic [AW-1:0] addr_in,
    output logic          flag,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            addr <= '0;
        end else begin
            flag <= set | (flag & ~clr);
            if (set && (!flag || clr))
                addr <= addr_in;
        end
    end

    assert_first_addr_kept_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(addr)));
    assert_set_flags_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/mem_err_log.sv
module mem_err_log
    import mel_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int RAW = 4,
    parameter int RDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_valid,
    input  logic [1:0]     ev_master,
    input  logic [AW-1:0]  ev_addr,
    input  logic           ev_sbe,
    input  logic           ev_dbe,
    input  logic           ev_addr_err,
    input  logic           ev_parity_ram,
    input  logic           ev_debug,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    output logic           corr_irq,
    output logic           nmi
);
    localparam int NM    = 3;
    localparam int NSLOT = NCLASS * NM;

    logic [NM-1:0]    corr_hit, unc_hit, afault_hit;
    logic [NSLOT-1:0] slot_set, slot_clr, slot_flag;
    logic [AW-1:0]    slot_addr [NSLOT];
    logic             irq_en;
    logic [CW-1:0]    thr;
    logic [CW-1:0]    count;
    logic             wr_ctrl, wr_thr, wr_flags;
    logic             nmi_q;

    mel_classify #(.NM(NM), .MW(2)) u_cls (
        .ev_valid(ev_valid), .ev_master(ev_master), .ev_sbe(ev_sbe),
        .ev_dbe(ev_dbe), .ev_addr_err(ev_addr_err),
        .ev_parity_ram(ev_parity_ram), .ev_debug(ev_debug),
        .corr_hit(corr_hit), .unc_hit(unc_hit), .afault_hit(afault_hit)
    );

    always_comb begin
        wr_ctrl  = reg_we && (int'(reg_addr) == REG_CTRL);
        wr_thr   = reg_we && (int'(reg_addr) == REG_THR);
        wr_flags = reg_we && (int'(reg_addr) == REG_FLAGS);
        slot_set = {afault_hit, unc_hit, corr_hit};
        slot_clr = wr_flags ? reg_wdata[NSLOT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            thr    <= '0;
        end else begin
            if (wr_ctrl) irq_en <= reg_wdata[0];
            if (wr_thr)  thr    <= reg_wdata[CW-1:0];
        end
    end

    mel_corr_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(|corr_hit),
        .clr(wr_ctrl && reg_wdata[1]), .thr_wr(wr_thr), .thr(thr),
        .irq_en(irq_en), .count(count), .irq(corr_irq)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        mel_log_slot #(.AW(AW)) u_slot (
            .clk(clk), .rst_n(rst_n), .set(slot_set[s]), .clr(slot_clr[s]),
            .addr_in(ev_addr), .flag(slot_flag[s]), .addr(slot_addr[s])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nmi_q <= 1'b0;
        else
            nmi_q <= (|unc_hit) || (|afault_hit);
    end
    assign nmi = nmi_q;

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == REG_CTRL)
            reg_rdata[0] = irq_en;
        else if (int'(reg_addr) == REG_THR)
            reg_rdata[CW-1:0] = thr;
        else if (int'(reg_addr) == REG_COUNT)
            reg_rdata[CW-1:0] = count;
        else if (int'(reg_addr) == REG_FLAGS)
            reg_rdata[NSLOT-1:0] = slot_flag;
        else
            for (int s = 0; s < NSLOT; s++)
                if (int'(reg_addr) == REG_ADDR0 + s)
                    reg_rdata[AW-1:0] = slot_addr[s];
    end

    assert_nmi_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi || $past(|unc_hit || |afault_hit));
    assert_afault_nmi_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_addr_err && ev_master != 2'd3) |=> nmi);
    assert_debug_mask_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_debug && !ev_addr_err) |=> (!nmi && $stable(count)));
    assert_bad_master_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_master == 2'd3 && !wr_ctrl) |=> (!nmi && $stable(count)));
endmodule

// File: tb/mem_err_log_test.sv
module mem_err_log_test;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 0, ev_sbe = 0, ev_dbe = 0, ev_addr_err = 0;
    logic        ev_parity_ram = 0, ev_debug = 0;
    logic [1:0]  ev_master = 0;
    logic [AW-1:0] ev_addr = 0;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        corr_irq, nmi;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    mem_err_log uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_master(ev_master),
        .ev_addr(ev_addr), .ev_sbe(ev_sbe), .ev_dbe(ev_dbe),
        .ev_addr_err(ev_addr_err), .ev_parity_ram(ev_parity_ram),
        .ev_debug(ev_debug), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .corr_irq(corr_irq), .nmi(nmi)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    // drive one report; returns at the falling edge where results are due
    task automatic send(input int m, input int a, input bit sbe, input bit dbe,
                        input bit ae, input bit par, input bit dbg);
        @(negedge clk);
        ev_valid = 1; ev_master = 2'(m); ev_addr = AW'(a);
        ev_sbe = sbe; ev_dbe = dbe; ev_addr_err = ae;
        ev_parity_ram = par; ev_debug = dbg;
        @(negedge clk);
        ev_valid = 0; ev_sbe = 0; ev_dbe = 0; ev_addr_err = 0; ev_debug = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2, v); chk("R1 reset count", v, 0);
        rd(3, v); chk("R7 reset flags", v, 0);
        chk("R2 reset irq", {31'b0, corr_irq}, 0);
        chk("R3 reset nmi", {31'b0, nmi}, 0);
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        wr(0, 1); wr(1, 3);
        send(0, 'h10, 1, 0, 0, 0, 0);
        chk("R2 below threshold", {31'b0, corr_irq}, 0);
        send(1, 'h11, 1, 0, 0, 0, 0);
        rd(2, v); chk("R1 count two", v, 2);
        send(0, 'h12, 1, 0, 0, 0, 0);
        chk("R2 irq at threshold", {31'b0, corr_irq}, 1);
        chk("R1 ecc single no nmi", {31'b0, nmi}, 0);
        step();
        chk("R2 irq single cycle", {31'b0, corr_irq}, 0);
        send(0, 'h13, 1, 0, 0, 0, 0);
        chk("R2 no repeat past threshold", {31'b0, corr_irq}, 0);
        rd(2, v); chk("R1 count four", v, 4);
        rd(3, v); chk("R6 corr flags cpu dma", v, 32'h3);
        rd(4, v); chk("R7 first cpu corr addr", v, 'h10);
        rd(5, v); chk("R6 dma corr addr", v, 'h11);
    endtask

    task automatic t_clear_and_zero();
        logic [31:0] v;
        wr(0, 32'h3);
        rd(2, v); chk("R8 count cleared", v, 0);
        wr(1, 0);
        send(2, 'h20, 1, 0, 0, 0, 0);
        chk("R2 zero threshold no irq", {31'b0, corr_irq}, 0);
        rd(2, v); chk("R6 coproc corr counted", v, 1);
        // clear in same cycle as an increment: clear wins
        @(negedge clk);
        reg_we = 1; reg_addr = 0; reg_wdata = 32'h3;
        ev_valid = 1; ev_master = 0; ev_sbe = 1; ev_parity_ram = 0;
        @(negedge clk);
        reg_we = 0; ev_valid = 0; ev_sbe = 0;
        rd(2, v); chk("R8 clear beats increment", v, 0);
        // disabled interrupt
        wr(1, 1); wr(0, 0);
        send(0, 'h21, 1, 0, 0, 0, 0);
        chk("R2 disabled no irq", {31'b0, corr_irq}, 0);
        wr(0, 32'h3);
    endtask

    task automatic t_uncorr();
        logic [31:0] v;
        wr(3, 32'h1FF);
        send(1, 'h30, 1, 0, 0, 1, 0);
        chk("R3 parity single nmi", {31'b0, nmi}, 1);
        rd(2, v); chk("R3 parity not counted", v, 0);
        step();
        chk("R3 nmi one cycle", {31'b0, nmi}, 0);
        send(0, 'h31, 0, 1, 0, 0, 0);
        chk("R3 ecc double nmi", {31'b0, nmi}, 1);
        rd(3, v); chk("R3 unc flags", v, 32'h18);
        rd(8, v); chk("R3 dma unc addr", v, 'h30);
        rd(7, v); chk("R3 cpu unc addr", v, 'h31);
    endtask

    task automatic t_afault_debug();
        logic [31:0] v;
        wr(3, 32'h1FF);
        send(2, 'h40, 0, 0, 1, 0, 1);
        chk("R4 afault under debug nmi", {31'b0, nmi}, 1);
        rd(3, v); chk("R4 afault flag coproc", v, 32'h100);
        rd(12, v); chk("R4 afault addr", v, 'h40);
        step();
        send(0, 'h41, 1, 1, 0, 0, 1);
        chk("R5 debug masks nmi", {31'b0, nmi}, 0);
        rd(3, v); chk("R5 debug no flags", v, 32'h100);
        rd(2, v); chk("R5 debug no count", v, 0);
        send(3, 'h42, 1, 1, 1, 0, 0);
        chk("R6 master3 no nmi", {31'b0, nmi}, 0);
        rd(3, v); chk("R6 master3 no flags", v, 32'h100);
    endtask

    task automatic t_sticky_both();
        logic [31:0] v;
        wr(3, 32'h1FF);
        send(1, 'h50, 1, 1, 0, 0, 0);
        chk("R9 both nmi", {31'b0, nmi}, 1);
        rd(3, v); chk("R9 both flags", v, 32'h12);
        rd(2, v); chk("R9 both counted", v, 1);
        send(1, 'h51, 1, 0, 0, 0, 0);
        rd(5, v); chk("R7 first addr kept", v, 'h50);
        wr(3, 32'h0);
        rd(3, v); chk("R7 write zero keeps", v, 32'h12);
        wr(3, 32'h2);
        rd(3, v); chk("R7 w1c clears one", v, 32'h10);
        send(1, 'h52, 1, 0, 0, 0, 0);
        rd(5, v); chk("R7 recapture after clear", v, 'h52);
    endtask

    task automatic t_saturate();
        logic [31:0] v;
        wr(0, 32'h3); wr(1, 0);
        @(negedge clk);
        ev_valid = 1; ev_master = 0; ev_sbe = 1; ev_parity_ram = 0;
        for (int i = 0; i < 260; i++) @(negedge clk);
        ev_valid = 0; ev_sbe = 0;
        rd(2, v); chk("R1 saturates", v, 255);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_threshold();
        t_clear_and_zero();
        t_uncorr();
        t_afault_debug();
        t_sticky_both();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule